// File: doc/BRIEF.md
# Frame-Atomic CAN Receive FIFO Read Port

This block holds received CAN frames in a FIFO and exposes them to a processor through a small register window. Every frame has four 32-bit words: identifier, length code, first data word and second data word. The receive logic upstream hands over a whole frame in one cycle on the push port. The frame is stored only if the FIFO has room for all four words. Otherwise it is dropped whole and an overflow status bit is set.

Software reads a frame by reading the identifier register first. When at least four words are stored, that single read removes the oldest frame from the FIFO. It latches all four of the frame's words into holding registers and returns the identifier. Reads of the length and data registers after that return the latched words and never touch the FIFO. If the identifier register is read while the FIFO holds fewer than four words, nothing is removed, the read returns the identifier that is already held, and an underflow status bit is set.

The two status bits are cleared by writing one to them. Each status bit is masked by an enable bit, and the results are ORed onto a single interrupt line. A separate output always shows how many words are stored.

Top module: `can_rx_frame_port`

## Requirements
- R1: After reset the word count is 0, both status bits and both enable bits are 0, the interrupt is low, the read data is 0 and the four holding registers are 0.
- R2: A push while the count is at most 4*DEPTH_FRAMES-4 stores the frame, and the count rises by 4 at the next clock edge.
- R3: A push while fewer than four words are free stores nothing and leaves the count unchanged. It sets overflow status (bit 1 of the status register at address 4).
- R4: A read of address 0 with at least four words stored removes the oldest frame, lowers the count by 4 and returns that frame's identifier on bus_rdata one cycle later. Frames leave in the order they were pushed.
- R5: Reads of address 1 (length), 2 (data 0) and 3 (data 1) return the words latched by the last successful address-0 read and leave the count unchanged.
- R6: Bits 27:16 of the latched length word always read as zero, whatever was pushed.
- R7: A read of address 0 with fewer than four words stored sets underflow status (bit 0 of address 4), leaves the count and holding registers unchanged, and returns the held identifier.
- R8: Writing address 4 clears each status bit written as one and leaves bits written as zero alone. An event in the same cycle as a clear of its own bit wins, so the bit stays set.
- R9: Address 5 is the enable register: bits 1:0 are writable and read back. The interrupt is high exactly when a status bit and its matching enable bit are both set.
- R10: Writes to addresses 0, 1, 2, 3 and 6 change nothing: not the count, not the holding registers, not the status.
- R11: A push and a successful address-0 read in the same cycle both take effect. Room for the push is judged on the count before that cycle's removal.
- R12: Address 6 reads the word count, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Offers a frame this cycle |
| push_id | input | 32 | Identifier word of the offered frame |
| push_len | input | 32 | Length-code word of the offered frame |
| push_d0 | input | 32 | First data word of the offered frame |
| push_d1 | input | 32 | Second data word of the offered frame |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe and held until the next read |
| irq | output | 1 | Interrupt: status bits masked by the enable bits, ORed together |
| rx_level | output | LVL_W | Number of 32-bit words stored |

## Verification
The bench builds the block with DEPTH_FRAMES set to 4, so the FIFO holds 16 words and becomes full after four pushes. That small depth puts the dropped push on a full FIFO within reach in a few cycles. It also makes a full FIFO meet a same-cycle removal, and lets the set-versus-clear race on overflow status be checked. A queue model updated on every clock gives the expected count, interrupt and read data. The model is compared with the outputs every cycle while the bench runs through empty, partly full and full states.

// File: rtl/can_rxp_pkg.sv
package can_rxp_pkg;

  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 4;
  localparam int STAT_W      = 2;
  localparam int STAT_UFLW   = 0;
  localparam int STAT_OFLW   = 1;

  localparam logic [WORD_W-1:0] LEN_RSVD_MASK = 32'h0FFF_0000;

  localparam int W_ID  = 0;
  localparam int W_LEN = 1;
  localparam int W_D0  = 2;
  localparam int W_D1  = 3;

  typedef logic [FRAME_WORDS-1:0][WORD_W-1:0] can_frame_t;

  typedef enum logic [2:0] {
    REG_ID    = 3'd0,
    REG_LEN   = 3'd1,
    REG_D0    = 3'd2,
    REG_D1    = 3'd3,
    REG_STAT  = 3'd4,
    REG_IEN   = 3'd5,
    REG_LEVEL = 3'd6
  } can_rxp_reg_e;

endpackage

// File: rtl/can_rxp_frame_store.sv
module can_rxp_frame_store
  import can_rxp_pkg::*;
#(
  parameter int DEPTH_FRAMES = 64,
  localparam int PTR_W = (DEPTH_FRAMES > 1) ? $clog2(DEPTH_FRAMES) : 1,
  localparam int CNT_W = $clog2(DEPTH_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  can_frame_t       push_frame,
  input  logic             pop_req,
  output can_frame_t       head_frame,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             push_ok,
  output logic             pop_ok
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH_FRAMES);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH_FRAMES - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_ok  = push_req && (cnt_q != CNT_FULL);
    pop_ok   = pop_req && (cnt_q != '0);
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // One bank per word position: a whole frame goes in or out in one cycle.
  for (genvar b = 0; b < FRAME_WORDS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH_FRAMES];
    always_ff @(posedge clk) begin
      if (push_ok) begin
        mem[wr_ptr_q] <= push_frame[b];
      end
    end
    assign head_frame[b] = mem[rd_ptr_q];
  end

  assign frame_cnt = cnt_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && cnt_q == CNT_FULL) |=> $stable(cnt_q));

  assert_pair_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q));

  assert_empty_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/can_rxp_hold.sv
module can_rxp_hold
  import can_rxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  can_frame_t frame_in,
  output can_frame_t held
);

  can_frame_t held_q, held_d;
  can_frame_t frame_clean;

  always_comb begin
    frame_clean        = frame_in;
    frame_clean[W_LEN] = frame_in[W_LEN] & ~LEN_RSVD_MASK;
    held_d             = load ? frame_clean : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= held_d;
    end
  end

  assign held = held_q;

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q));

  assert_len_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((held_q[W_LEN] & LEN_RSVD_MASK) == '0));

endmodule

// File: rtl/can_rxp_csr.sv
module can_rxp_csr
  import can_rxp_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  can_frame_t        head_frame,
  input  can_frame_t        held_frame,
  input  logic              frame_avail,
  input  logic              push_drop,
  input  logic [LVL_W-1:0]  level,
  output logic              pop_req,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);

  logic              rd_en, wr_en, id_rd, uflw_ev;
  logic [STAT_W-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic [STAT_W-1:0] ien_q, ien_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  can_rxp_reg_e      reg_sel;

  always_comb begin
    reg_sel  = can_rxp_reg_e'(bus_addr);
    rd_en    = bus_sel && !bus_wr;
    wr_en    = bus_sel && bus_wr;
    id_rd    = rd_en && (reg_sel == REG_ID);
    pop_req  = id_rd && frame_avail;
    uflw_ev  = id_rd && !frame_avail;

    stat_set            = '0;
    stat_set[STAT_UFLW] = uflw_ev;
    stat_set[STAT_OFLW] = push_drop;
    stat_clr = (wr_en && reg_sel == REG_STAT) ? bus_wdata[STAT_W-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
    ien_d    = (wr_en && reg_sel == REG_IEN) ? bus_wdata[STAT_W-1:0] : ien_q;

    rdata_d = rdata_q;
    if (rd_en) begin
      case (reg_sel)
        REG_ID:    rdata_d = frame_avail ? head_frame[W_ID] : held_frame[W_ID];
        REG_LEN:   rdata_d = held_frame[W_LEN];
        REG_D0:    rdata_d = held_frame[W_D0];
        REG_D1:    rdata_d = held_frame[W_D1];
        REG_STAT:  rdata_d = WORD_W'(stat_q);
        REG_IEN:   rdata_d = WORD_W'(ien_q);
        REG_LEVEL: rdata_d = WORD_W'(level);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ien_q   <= '0;
      rdata_q <= '0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
      if (rd_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(stat_q & ien_q);

  assert_uflw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd0 && !frame_avail) |=> stat_q[STAT_UFLW]);

  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd4 && bus_wdata[STAT_OFLW] && !push_drop)
      |=> !stat_q[STAT_OFLW]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> stat_q[STAT_OFLW]);

  assert_no_side_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_wr || bus_addr != 3'd0)) |-> !pop_req);

  assert_ien_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 3'd5) |=> $stable(ien_q));

endmodule

// File: rtl/can_rx_frame_port.sv
module can_rx_frame_port
  import can_rxp_pkg::*;
#(
  parameter int DEPTH_FRAMES = 64,
  localparam int CNT_W = $clog2(DEPTH_FRAMES + 1),
  localparam int LVL_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [31:0]      push_id,
  input  logic [31:0]      push_len,
  input  logic [31:0]      push_d0,
  input  logic [31:0]      push_d1,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic [LVL_W-1:0] rx_level
);

  logic             rst_meta_q, rst_sync_q;
  can_frame_t       push_frame, head_frame, held_frame;
  logic [CNT_W-1:0] frame_cnt;
  logic             push_ok, pop_ok, pop_req, push_drop;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    push_frame        = '0;
    push_frame[W_ID]  = push_id;
    push_frame[W_LEN] = push_len;
    push_frame[W_D0]  = push_d0;
    push_frame[W_D1]  = push_d1;
    push_drop         = push_valid && !push_ok;
  end

  can_rxp_frame_store #(
    .DEPTH_FRAMES(DEPTH_FRAMES)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .push_req   (push_valid),
    .push_frame (push_frame),
    .pop_req    (pop_req),
    .head_frame (head_frame),
    .frame_cnt  (frame_cnt),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok)
  );

  can_rxp_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (pop_ok),
    .frame_in (head_frame),
    .held     (held_frame)
  );

  can_rxp_csr #(
    .LVL_W(LVL_W)
  ) u_csr (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .head_frame  (head_frame),
    .held_frame  (held_frame),
    .frame_avail (frame_cnt != '0),
    .push_drop   (push_drop),
    .level       (rx_level),
    .pop_req     (pop_req),
    .bus_rdata   (bus_rdata),
    .irq         (irq)
  );

  assign rx_level = {frame_cnt, 2'b00};

  assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pop_req && !push_valid) |=> (rx_level == $past(rx_level) - LVL_W'(4)));

endmodule

// File: tb/can_rx_frame_port_tb_top.sv
module can_rx_frame_port_tb_top;

  localparam int DF    = 4;
  localparam int WORDS = 4 * DF;
  localparam int LW    = $clog2(DF + 1) + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic [31:0]   push_id = '0, push_len = '0, push_d0 = '0, push_d1 = '0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;
  logic [LW-1:0] rx_level;

  always #4 clk = ~clk;

  can_rx_frame_port #(.DEPTH_FRAMES(DF)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_id(push_id),
    .push_len(push_len), .push_d0(push_d0), .push_d1(push_d1),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_level(rx_level)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;
  bit    cmp_on = 0;
  string cur_tag = "R1";

  // Behavioural reference model.
  logic [31:0] mq[$];
  logic [31:0] m_hold[4];
  logic [1:0]  m_st, m_en;
  logic [31:0] m_rdata;
  int          m_cnt;
  logic [1:0]  m_set, m_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < 4; i++) m_hold[i] = '0;
      m_st = '0; m_en = '0; m_rdata = '0;
    end else begin
      m_cnt = mq.size();
      m_set = '0;
      m_clr = '0;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          3'd0: m_rdata = (m_cnt >= 4) ? mq[0] : m_hold[0];
          3'd1: m_rdata = m_hold[1];
          3'd2: m_rdata = m_hold[2];
          3'd3: m_rdata = m_hold[3];
          3'd4: m_rdata = {30'd0, m_st};
          3'd5: m_rdata = {30'd0, m_en};
          3'd6: m_rdata = 32'(m_cnt);
          default: m_rdata = '0;
        endcase
        if (bus_addr == 3'd0) begin
          if (m_cnt >= 4) begin
            for (int i = 0; i < 4; i++) m_hold[i] = mq.pop_front();
            m_hold[1] = m_hold[1] & 32'hF000_FFFF;
          end else begin
            m_set[0] = 1'b1;
          end
        end
      end
      if (push_valid) begin
        if (m_cnt <= WORDS - 4) begin
          mq.push_back(push_id); mq.push_back(push_len);
          mq.push_back(push_d0); mq.push_back(push_d1);
        end else begin
          m_set[1] = 1'b1;
        end
      end
      if (bus_sel && bus_wr && bus_addr == 3'd4) m_clr = bus_wdata[1:0];
      if (bus_sel && bus_wr && bus_addr == 3'd5) m_en = bus_wdata[1:0];
      m_st = (m_st & ~m_clr) | m_set;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_tag, " level"}, 32'(rx_level), 32'(mq.size()));
      chk({cur_tag, " irq"}, 32'(irq), 32'(|(m_st & m_en)));
      chk({cur_tag, " rdata"}, bus_rdata, m_rdata);
    end
  end

  function automatic logic [31:0] fid(input int k);  return 32'h1000_0000 + k; endfunction
  function automatic logic [31:0] flen(input int k); return 32'hFFFF_0008 | k; endfunction
  function automatic logic [31:0] fd0(input int k);  return 32'hA000_0000 + k; endfunction
  function automatic logic [31:0] fd1(input int k);  return 32'hB000_0000 + k; endfunction

  // One cycle: optional bus access and optional push of frame k.
  task automatic cyc(input bit sel, input bit wr, input logic [2:0] a,
                     input logic [31:0] wd, input bit push, input int k);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    push_valid = push;
    push_id = fid(k); push_len = flen(k); push_d0 = fd0(k); push_d1 = fd1(k);
    @(negedge clk);
    bus_sel = 1'b0; push_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);     cyc(1, 0, a, '0, 0, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic push(input int k);           cyc(0, 0, 3'd0, '0, 1, k); endtask
  task automatic idle();                       cyc(0, 0, 3'd0, '0, 0, 0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    cur_tag = "R1";
    chk("R1 level", 32'(rx_level), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd1); chk("R1 held len", bus_rdata, 0);
    rd(3'd5); chk("R1 enable", bus_rdata, 0);

    cur_tag = "R7";
    rd(3'd0); chk("R7 empty id read", bus_rdata, 0);
    rd(3'd4); chk("R7 underflow bit", bus_rdata, 1);

    cur_tag = "R9";
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R9 irq on", 32'(irq), 1);
    rd(3'd5); chk("R9 enable readback", bus_rdata, 3);

    cur_tag = "R8";
    wr(3'd4, 0); rd(3'd4); chk("R8 write zero keeps", bus_rdata, 1);
    wr(3'd4, 1); chk("R8 irq cleared", 32'(irq), 0);
    rd(3'd4); chk("R8 cleared", bus_rdata, 0);

    cur_tag = "R2";
    for (int k = 0; k < DF; k++) push(k);
    chk("R2 level full", 32'(rx_level), WORDS);

    cur_tag = "R3";
    push(99);
    chk("R3 level kept", 32'(rx_level), WORDS);
    chk("R3 irq", 32'(irq), 1);
    rd(3'd4); chk("R3 overflow bit", bus_rdata, 2);
    wr(3'd4, 2);

    cur_tag = "R10";
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF);
    chk("R10 level kept", 32'(rx_level), WORDS);
    rd(3'd1); chk("R10 hold kept", bus_rdata, 0);
    rd(3'd4); chk("R10 status kept", bus_rdata, 0);

    cur_tag = "R4";
    rd(3'd0); chk("R4 first id", bus_rdata, fid(0));
    chk("R4 level down", 32'(rx_level), WORDS - 4);

    cur_tag = "R6";
    rd(3'd1); chk("R6 len reserved zero", bus_rdata, 32'hF000_0008);

    cur_tag = "R5";
    rd(3'd2); chk("R5 data0", bus_rdata, fd0(0));
    rd(3'd3); chk("R5 data1", bus_rdata, fd1(0));
    rd(3'd1); chk("R5 len again", bus_rdata, 32'hF000_0008);
    chk("R5 level kept", 32'(rx_level), WORDS - 4);

    cur_tag = "R12";
    rd(3'd6); chk("R12 level reg", bus_rdata, WORDS - 4);
    rd(3'd7); chk("R12 unmapped", bus_rdata, 0);

    cur_tag = "R11";
    cyc(1, 0, 3'd0, '0, 1, 5);
    chk("R11 id", bus_rdata, fid(1));
    chk("R11 level", 32'(rx_level), WORDS - 4);
    push(6);
    chk("R11 full again", 32'(rx_level), WORDS);
    cyc(1, 0, 3'd0, '0, 1, 7);
    chk("R11 full pair id", bus_rdata, fid(2));
    chk("R11 full pair level", 32'(rx_level), WORDS - 4);
    rd(3'd4); chk("R11 full pair overflow", bus_rdata, 2);
    wr(3'd4, 3);

    cur_tag = "R4";
    rd(3'd0); chk("R4 order 3", bus_rdata, fid(3));
    rd(3'd0); chk("R4 order 5", bus_rdata, fid(5));
    rd(3'd0); chk("R4 order 6", bus_rdata, fid(6));
    chk("R4 drained", 32'(rx_level), 0);

    cur_tag = "R7";
    rd(3'd0); chk("R7 held id returned", bus_rdata, fid(6));
    rd(3'd3); chk("R7 hold kept", bus_rdata, fd1(6));
    chk("R7 level kept", 32'(rx_level), 0);
    rd(3'd4); chk("R7 underflow again", bus_rdata, 1);
    wr(3'd4, 1);

    cur_tag = "R8";
    for (int k = 0; k < DF; k++) push(10 + k);
    cyc(1, 1, 3'd4, 32'h2, 1, 20);
    rd(3'd4); chk("R8 set wins over clear", bus_rdata, 2);
    chk("R8 irq held", 32'(irq), 1);

    idle();
    cmp_on = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule